// File: doc/BRIEF.md
# Group-Conflict Age Selector

This block sits beside an issue queue. It grants one ready instruction per issue port each cycle. It also hands out and takes back the slot tags that instructions carry while they are in the queue. The ready list is presented as a vector of entries, each a valid bit and a slot tag, ordered by age with index 0 the oldest. Each port can raise a select request. Ports are served in ascending order within a cycle, and every later port sees what the earlier ports took.

A port does not always take the oldest ready entry. A slot tag belongs to a bank group, which is the tag modulo the group size. A port skips any entry whose group matches a group already granted in the same cycle. Grants never carry over from one cycle to the next. The queue size must be an exact multiple of the group size, and any other configuration stops elaboration with an error.

Slot tags come from a first-in first-out free list. At reset the list holds every tag from 0 to size-1 in ascending order. An allocation takes the tag at the head of the list and a release appends the tag at the tail. The all-ones tag value means "no tag" (invalid). A request that cannot be honoured raises an error flag and does not change the list.

Top module: `grp_age_sel`

## Requirements
- R1: After reset, consecutive accepted allocations return the tags 0, 1, ..., QSIZE-1 in that order.
- R2: While `alloc_req` is high and the list is not empty, `alloc_tag` shows the head tag in the same cycle, and that tag is consumed at the clock edge. While `alloc_req` is low, `alloc_tag` is all ones (the invalid tag, 31 with default parameters).
- R3: An accepted release appends its tag at the tail, so released tags are later allocated in the order they were released.
- R4: A requesting port with no earlier-port grant in the same cycle is granted the lowest-index (oldest) valid entry.
- R5: A requesting port after an earlier grant is given the lowest-index valid entry whose group (tag modulo GROUP) differs from the groups of all entries granted to lower-numbered ports in that cycle. A port that does not request adds no group.
- R6: A port with no request, or with no entry that passes the group check, drives `sel_none`=1 and `sel_idx`=0.
- R7: The set of groups granted is rebuilt every cycle. The grants depend only on the current ready vector and requests, not on earlier cycles.
- R8: An allocation when the list is empty raises `err` in that cycle and keeps `alloc_tag` at all ones. No tag is consumed.
- R9: A release with a tag of QSIZE or more, or a release while the list is full, raises `err` in that cycle and does not change the list.
- R10: An allocation and a release in the same cycle are both applied. The released tag goes behind the tags already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a slot tag |
| alloc_tag | output | TAGW | Tag assigned this cycle, all ones if none |
| free_req | input | 1 | Return a slot tag |
| free_tag | input | TAGW | Tag being returned |
| err | output | 1 | Rejected allocation or release this cycle |
| rdy_vld | input | NREADY | Valid bit per ready entry, bit 0 oldest |
| rdy_tag | input | NREADY*TAGW | Slot tag per entry, entry i at bits [i*TAGW +: TAGW] |
| sel_req | input | NPORTS | Select request per port |
| sel_idx | output | NPORTS*IDXW | Granted entry index per port, port p at [p*IDXW +: IDXW] |
| sel_none | output | NPORTS | Port p granted nothing |

## Verification
The selection is tried with several ready vectors:
- A vector with mixed groups shows that each port steps past the groups taken before it.
- A vector with a single group shows that only the first port is served.
- An empty vector and a sparse vector exercise the no-grant path.
- One pattern leaves a middle port idle, which shows that an idle port adds no group.
- One pattern idles the first port, which shows that the next port then takes the oldest entry unconditionally.

Repeating a pattern after different ones separates per-cycle behaviour from any carried-over state. The tag list is drained, refilled out of order, and driven into both of its rejection cases: allocation from an empty list and release into a full list. This tells apart head/tail ordering from stack-like reuse.

// File: rtl/gsel_pkg.sv
package gsel_pkg;
  // Bank group of a slot tag
  function automatic int unsigned grp_of(input int unsigned tag, input int unsigned gsize);
    return tag % gsize;
  endfunction

  // Circular pointer advance
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/gsel_freelist.sv
module gsel_freelist #(
  parameter int QSIZE = 16,
  parameter int TAGW  = $clog2(QSIZE) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  output logic [TAGW-1:0] alloc_tag,
  input  logic            free_req,
  input  logic [TAGW-1:0] free_tag,
  output logic            err
);
  import gsel_pkg::*;
  localparam int PW = (QSIZE > 1) ? $clog2(QSIZE) : 1;
  localparam int CW = $clog2(QSIZE + 1);
  localparam logic [TAGW-1:0] QLIM = TAGW'(QSIZE);
  localparam logic [CW-1:0]   FULL = CW'(QSIZE);

  logic [TAGW-1:0] mem [QSIZE];
  logic [PW-1:0]   head, tail;
  logic [CW-1:0]   cnt, cnt_nxt;

  // named events
  logic list_empty, list_full, alloc_go, alloc_bad, free_go, free_bad;

  assign list_empty = (cnt == '0);
  assign list_full  = (cnt == FULL);
  assign alloc_go   = alloc_req && !list_empty;
  assign alloc_bad  = alloc_req && list_empty;
  assign free_bad   = free_req && ((free_tag >= QLIM) || list_full);
  assign free_go    = free_req && !free_bad;
  assign err        = alloc_bad || free_bad;
  assign alloc_tag  = alloc_go ? mem[head] : '1;

  always_comb begin
    cnt_nxt = cnt;
    if (alloc_go) cnt_nxt = cnt_nxt - 1'b1;
    if (free_go)  cnt_nxt = cnt_nxt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < QSIZE; i++) mem[i] <= TAGW'(i);
      head <= '0;
      tail <= '0;
      cnt  <= FULL;
    end else begin
      if (alloc_go) head <= PW'(ring_next(32'(head), QSIZE));
      if (free_go) begin
        mem[tail] <= free_tag;
        tail      <= PW'(ring_next(32'(tail), QSIZE));
      end
      cnt <= cnt_nxt;
    end
  end

  // R2: an accepted allocation alone shrinks the list by one
  p_alloc_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && !free_req) |=> (cnt == $past(cnt) - 1'b1));
  // R8: allocating from an empty list consumes nothing
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_bad && !free_req) |=> ($stable(cnt) && $stable(head)));
  // R9: a rejected release leaves the tail and count untouched
  p_bad_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_bad && !alloc_req) |=> ($stable(cnt) && $stable(tail)));
  // R10: simultaneous accepted alloc and release keep the count
  p_both_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && free_go) |=> $stable(cnt));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
endmodule

// File: rtl/gsel_pick.sv
module gsel_pick #(
  parameter int NREADY = 8,
  parameter int TAGW   = 5,
  parameter int GROUP  = 4,
  parameter int IDXW   = $clog2(NREADY)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [NREADY-1:0]      vld,
  input  logic [NREADY*TAGW-1:0] tags,
  input  logic [GROUP-1:0]       used_in,
  output logic [IDXW-1:0]        idx,
  output logic                   none,
  output logic [GROUP-1:0]       used_out
);
  import gsel_pkg::*;
  localparam int GW = $clog2(GROUP);

  logic          hit;
  logic [GW-1:0] hit_grp;

  always_comb begin
    logic [GW-1:0] g;
    hit     = 1'b0;
    idx     = '0;
    hit_grp = '0;
    for (int i = 0; i < NREADY; i++) begin
      g = GW'(grp_of(32'(tags[i*TAGW +: TAGW]), GROUP));
      if (!hit && req && vld[i] && !used_in[g]) begin
        hit     = 1'b1;
        idx     = IDXW'(i);
        hit_grp = g;
      end
    end
  end

  assign none     = !hit;
  assign used_out = hit ? (used_in | (GROUP'(1) << hit_grp)) : used_in;

  // R5: a grant points at a valid entry of a fresh group
  p_grant_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !none |-> (vld[idx] && !used_in[GW'(grp_of(32'(tags[idx*TAGW +: TAGW]), GROUP))]));
  // R6: no request means no grant and no new group
  p_idle_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (none && idx == '0 && used_out == used_in));
endmodule

// File: rtl/grp_age_sel.sv
module grp_age_sel #(
  parameter int QSIZE  = 16,
  parameter int GROUP  = 4,
  parameter int NPORTS = 3,
  parameter int NREADY = 8,
  parameter int TAGW   = $clog2(QSIZE) + 1,
  parameter int IDXW   = $clog2(NREADY)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  output logic [TAGW-1:0]          alloc_tag,
  input  logic                     free_req,
  input  logic [TAGW-1:0]          free_tag,
  output logic                     err,
  input  logic [NREADY-1:0]        rdy_vld,
  input  logic [NREADY*TAGW-1:0]   rdy_tag,
  input  logic [NPORTS-1:0]        sel_req,
  output logic [NPORTS*IDXW-1:0]   sel_idx,
  output logic [NPORTS-1:0]        sel_none
);
  import gsel_pkg::*;

  if (GROUP < 2 || (QSIZE % GROUP) != 0) begin : g_bad_cfg
    $error("grp_age_sel: QSIZE must be a multiple of GROUP (GROUP >= 2)");
  end

  gsel_freelist #(.QSIZE(QSIZE), .TAGW(TAGW)) u_flist (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_tag(alloc_tag),
    .free_req(free_req), .free_tag(free_tag), .err(err)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [GROUP-1:0] used_i, used_o;
    if (p == 0) begin : g_first
      assign used_i = '0;
    end else begin : g_next
      assign used_i = g_port[p-1].used_o;
    end
    gsel_pick #(.NREADY(NREADY), .TAGW(TAGW), .GROUP(GROUP), .IDXW(IDXW)) u_pick (
      .clk(clk), .rst_n(rst_n),
      .req(sel_req[p]), .vld(rdy_vld), .tags(rdy_tag),
      .used_in(used_i),
      .idx(sel_idx[p*IDXW +: IDXW]), .none(sel_none[p]),
      .used_out(used_o)
    );
  end

  // R5: no two ports granted in one cycle share a group
  for (genvar a = 0; a < NPORTS; a++) begin : g_pa
    for (genvar b = a + 1; b < NPORTS; b++) begin : g_pb
      p_no_grp_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_none[a] && !sel_none[b]) |->
          (grp_of(32'(rdy_tag[sel_idx[a*IDXW +: IDXW]*TAGW +: TAGW]), GROUP) !=
           grp_of(32'(rdy_tag[sel_idx[b*IDXW +: IDXW]*TAGW +: TAGW]), GROUP)));
    end
  end

  // R4: port 0 takes the oldest valid entry whenever one exists
  p_oldest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req[0] && rdy_vld != '0) |->
      (!sel_none[0] && ((rdy_vld & ((NREADY'(1) << sel_idx[IDXW-1:0]) - 1'b1)) == '0)));
endmodule

// File: tb/sim_grp_age_sel.sv
module sim_grp_age_sel;
  localparam int QSIZE = 16, GROUP = 4, NPORTS = 3, NREADY = 8, TAGW = 5, IDXW = 3;
  localparam logic [TAGW-1:0] INV = '1;
  // vector: {vld[8], tags[40] (entry7..entry0), req[3], exp_idx[9] (p2,p1,p0), exp_none[3]}
  localparam int VW = 63;
  localparam logic [VW-1:0] TBL [7] = '{
    // R4/R5 mixed groups: grants 0,3,5
    {8'hFF, {5'd6,5'd3,5'd2,5'd5,5'd1,5'd8,5'd4,5'd0}, 3'b111, {3'd5,3'd3,3'd0}, 3'b000},
    // R5/R6 one group only: only port 0 served
    {8'hFF, {5'd12,5'd8,5'd4,5'd0,5'd12,5'd8,5'd4,5'd0}, 3'b111, {3'd0,3'd0,3'd0}, 3'b110},
    // R6 empty ready list
    {8'h00, {5'd6,5'd3,5'd2,5'd5,5'd1,5'd8,5'd4,5'd0}, 3'b111, {3'd0,3'd0,3'd0}, 3'b111},
    // R4 port 0 idle: port 1 takes the oldest
    {8'hFF, {5'd6,5'd3,5'd2,5'd5,5'd1,5'd8,5'd4,5'd0}, 3'b110, {3'd3,3'd0,3'd0}, 3'b001},
    // R5/R6 sparse: entries 2,5,7 valid, port 2 finds nothing
    {8'hA4, {5'd6,5'd3,5'd2,5'd5,5'd1,5'd8,5'd4,5'd0}, 3'b111, {3'd0,3'd5,3'd2}, 3'b100},
    // R5 idle middle port adds no group
    {8'hFF, {5'd0,5'd0,5'd3,5'd3,5'd2,5'd2,5'd1,5'd1}, 3'b101, {3'd2,3'd0,3'd0}, 3'b010},
    // R7 first pattern again after others: same grants
    {8'hFF, {5'd6,5'd3,5'd2,5'd5,5'd1,5'd8,5'd4,5'd0}, 3'b111, {3'd5,3'd3,3'd0}, 3'b000}
  };

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0, free_req = 0, err;
  logic [TAGW-1:0] alloc_tag, free_tag = '0;
  logic [NREADY-1:0] rdy_vld = '0;
  logic [NREADY*TAGW-1:0] rdy_tag = '0;
  logic [NPORTS-1:0] sel_req = '0, sel_none;
  logic [NPORTS*IDXW-1:0] sel_idx;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  grp_age_sel u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one allocation cycle: drive, check combinational outputs, clock it in
  task automatic do_alloc(input string req, input int exp_tag, input int exp_err);
    @(negedge clk); alloc_req = 1; free_req = 0;
    #5 chk(req, alloc_tag, exp_tag); chk(req, err, exp_err);
    @(negedge clk); alloc_req = 0;
  endtask

  task automatic do_free(input string req, input int tag, input int exp_err);
    @(negedge clk); free_req = 1; free_tag = TAGW'(tag); alloc_req = 0;
    #5 chk(req, err, exp_err);
    @(negedge clk); free_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #5 chk("R2 reset idle tag", alloc_tag, INV); chk("R8 reset no err", err, 0);
    chk("R6 reset no request", sel_none, 3'b111);

    // table walk
    for (int v = 0; v < 7; v++) begin
      @(negedge clk);
      rdy_vld = TBL[v][62:55];
      rdy_tag = TBL[v][54:15];
      sel_req = TBL[v][14:12];
      #5;
      for (int p = 0; p < NPORTS; p++) begin
        chk($sformatf("R4/R5/R6/R7 vec%0d port%0d idx", v, p),
            sel_idx[p*IDXW +: IDXW], TBL[v][3 + p*IDXW +: IDXW]);
        chk($sformatf("R5/R6/R7 vec%0d port%0d none", v, p),
            sel_none[p], TBL[v][p]);
      end
    end
    @(negedge clk); sel_req = '0; rdy_vld = '0;

    // R1: reset order of tags
    for (int i = 0; i < QSIZE; i++) do_alloc("R1 ascending tag", i, 0);
    // R8: empty list
    do_alloc("R8 empty alloc", INV, 1);
    // R9: out-of-range release
    do_free("R9 out-of-range free", 20, 1);
    // R3: release order preserved
    do_free("R3 free 7", 7, 0);
    do_free("R3 free 3", 3, 0);
    do_free("R3 free 11", 11, 0);
    do_alloc("R3 fifo order first", 7, 0);
    // R10: simultaneous alloc and release
    @(negedge clk); alloc_req = 1; free_req = 1; free_tag = 5'd5;
    #5 chk("R10 alloc with free", alloc_tag, 3); chk("R10 no err", err, 0);
    @(negedge clk); alloc_req = 0; free_req = 0;
    do_alloc("R10 older tag first", 11, 0);
    do_alloc("R10 released tag behind", 5, 0);
    do_alloc("R8 drained again", INV, 1);
    // refill to full, then reject one more
    for (int i = 0; i < QSIZE; i++) do_free("R9 refill", (i * 5) % QSIZE, 0);
    do_free("R9 free into full list", 2, 1);
    do_alloc("R9 list unchanged head", 0, 0);
    do_alloc("R3 refill order", 5, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule